// File: doc/BRIEF.md
# Burst-Mode Oversampled Phase Selector

This block recovers serial data from upstream bursts. Each burst arrives at the same frequency as the local bit clock, but its phase is unknown. In every bit-clock cycle the block receives a vector of eight samples of the line. Sample k is taken k/8 of a bit period after the start of the local bit, so sample 0 is the earliest. A falling edge on the burst reset input starts a new acquisition.

An acquisition runs in three steps:
- The block waits out a short initialization window.
- It watches an alternating 1010... preamble for eight bits and records where the data edges fall among the eight sample slots.
- It then picks the slot half a bit away from the most common edge, so that the chosen sample sits at the centre of the data eye.

Samples from the chosen slot pass through a short synchronizer to a serial output. That output has a constant latency whatever phase is chosen. A lock flag marks the point where the output carries valid data. Until lock, both the data output and the lock flag stay low.

Top module: `burst_phase_picker`

## Requirements
- R1: While rst_n is low and directly after it is released, lock, sdo and phase_sel are all 0.
- R2: Acquisition starts only on a falling edge of burst_rst, that is, a cycle where burst_rst is 0 and it was 1 in the cycle before. Call that cycle F. A rising edge, or a level held high or held low, leaves lock unchanged.
- R3: In cycles F+1 to F+4 the sample input has no effect on the phase that is chosen.
- R4: In cycles F+6 to F+13, each cycle records an edge at every slot k where a transition is seen. For k of 1 or more, a transition means samp[k] differs from samp[k-1]. For k = 0, it means samp[0] differs from samp[7] of the previous cycle. The slot that records the most edges is the edge phase. On a tie, the lowest index wins.
- R5: From cycle F+15, phase_sel equals (edge phase + 4) mod 8. It does not change while lock is high.
- R6: lock is 0 in cycle F+16 and 1 in cycle F+17.
- R7: From cycle F+1 until lock rises, lock and sdo are both 0.
- R8: While lock is high, sdo in cycle c equals the data bit whose samples arrived in cycle c-3, for every one of the eight edge phases.
- R9: Once lock is high, it stays high up to and including the next cycle F. From cycle F+1 it is 0, which also restarts an acquisition that is already under way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_rst | input | 1 | Burst reset; its falling edge starts acquisition |
| samp | input | 8 | Line samples for this bit; bit k taken at k/8 of the bit |
| sdo | output | 1 | Recovered serial data; 0 while unlocked |
| lock | output | 1 | High while sdo carries valid burst data |
| phase_sel | output | 3 | Sample slot chosen for the current burst |

## Verification
The bench uses the default parameters: eight phases, a five-cycle initialization window, eight measured bits and three settle cycles. These settings make each of the eight input edge offsets a separate case. The offsets divide between the two output paths: edge phases below four take the extra stage, and the others take the direct path. A recovered payload that is correct to the bit, with lock rising in exactly the same cycle for every offset, shows that the two paths line up. With eight measured bits it is also possible to build a split of five edges against three and an exact tie of four against four, so the vote and its tie rule can be tested.

// File: rtl/burst_phase_picker.sv
module burst_phase_picker #(
  parameter int PHASES        = 8,
  parameter int INIT_CYCLES   = 5,
  parameter int MEAS_BITS     = 8,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      burst_rst,
  input  logic [PHASES-1:0]         samp,
  output logic                      sdo,
  output logic                      lock,
  output logic [$clog2(PHASES)-1:0] phase_sel
);
  localparam int PW   = $clog2(PHASES);
  localparam int CW   = $clog2(MEAS_BITS + 1);
  localparam int HALF = PHASES / 2;
  localparam int TMAX = (INIT_CYCLES > MEAS_BITS) ?
                        ((INIT_CYCLES > SETTLE_CYCLES) ? INIT_CYCLES : SETTLE_CYCLES) :
                        ((MEAS_BITS > SETTLE_CYCLES) ? MEAS_BITS : SETTLE_CYCLES);
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_MEAS, S_SETTLE, S_LOCK} st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic              br_d;
  logic [PHASES-1:0] s_q;
  logic [PHASES-1:0] tr;
  logic [CW-1:0]     hits [PHASES];
  logic [PW-1:0]     best;
  logic [CW-1:0]     best_n;
  logic              late_q, d1, dq, tap, aligned;

  wire fall = br_d & ~burst_rst;

  assign tr = samp ^ {samp[PHASES-2:0], s_q[PHASES-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_d <= 1'b0;
      s_q  <= '0;
    end else begin
      br_d <= burst_rst;
      s_q  <= samp;
    end
  end

  generate
    for (genvar g = 0; g < PHASES; g++) begin : g_hits
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     hits[g] <= '0;
        else if (fall)                  hits[g] <= '0;
        else if (st == S_MEAS && tr[g]) hits[g] <= hits[g] + 1'b1;
      end
    end
  endgenerate

  always_comb begin
    best   = '0;
    best_n = hits[0];
    for (int k = 1; k < PHASES; k++) begin
      if (hits[k] > best_n) begin
        best_n = hits[k];
        best   = PW'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      tmr <= '0;
    end else if (fall) begin
      st  <= S_INIT;
      tmr <= '0;
    end else begin
      case (st)
        S_INIT:
          if (tmr == TW'(INIT_CYCLES - 1)) begin st <= S_MEAS; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_MEAS:
          if (tmr == TW'(MEAS_BITS - 1)) begin st <= S_SETTLE; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_SETTLE:
          if (tmr == TW'(SETTLE_CYCLES - 1)) begin st <= S_LOCK; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        default: tmr <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_sel <= '0;
      late_q    <= 1'b0;
    end else if (st == S_SETTLE && tmr == '0 && !fall) begin
      phase_sel <= best + PW'(HALF);
      late_q    <= (best < PW'(HALF));
    end
  end

  assign tap     = s_q[phase_sel];
  assign aligned = late_q ? d1 : tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= 1'b0;
      dq <= 1'b0;
    end else begin
      d1 <= tap;
      dq <= aligned;
    end
  end

  assign lock = (st == S_LOCK);
  assign sdo  = lock & dq;
endmodule

module burst_phase_picker_chk #(
  parameter int PHASES        = 8,
  parameter int INIT_CYCLES   = 5,
  parameter int MEAS_BITS     = 8,
  parameter int SETTLE_CYCLES = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      burst_rst,
  input logic                      sdo,
  input logic                      lock,
  input logic [$clog2(PHASES)-1:0] phase_sel
);
  localparam int LOCK_AT = INIT_CYCLES + MEAS_BITS + SETTLE_CYCLES + 1;

  logic       prev_br;
  logic [7:0] since;
  wire        fell = prev_br & ~burst_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_br <= 1'b0;
      since   <= 8'hFF;
    end else begin
      prev_br <= burst_rst;
      if (fell)               since <= 8'd1;
      else if (since != 8'hFF) since <= since + 8'd1;
    end
  end

  assert_lock_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> since == 8'(LOCK_AT));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> !sdo);
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !lock);
  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !fell) |=> lock);
  assert_sel_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> $stable(phase_sel));
endmodule

bind burst_phase_picker burst_phase_picker_chk #(
  .PHASES(PHASES), .INIT_CYCLES(INIT_CYCLES),
  .MEAS_BITS(MEAS_BITS), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_rst(burst_rst),
  .sdo(sdo), .lock(lock), .phase_sel(phase_sel)
);

// File: tb/tb_burst_phase_picker.sv
module tb_burst_phase_picker;
  localparam int EDGE     = 2;
  localparam int LAT      = 3;
  localparam int LOCK_OFS = 17;
  localparam bit [5:0] TBL [0:7] = '{6'o04, 6'o15, 6'o26, 6'o37,
                                     6'o40, 6'o51, 6'o62, 6'o73};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_rst = 1'b1;
  logic [7:0] samp = '0;
  logic       sdo, lock;
  logic [2:0] phase_sel;
  int         checks = 0;
  int         errors = 0;
  bit         dat [0:63];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  burst_phase_picker dut (
    .clk(clk), .rst_n(rst_n), .burst_rst(burst_rst), .samp(samp),
    .sdo(sdo), .lock(lock), .phase_sel(phase_sel)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] mk(bit prev, bit cur, int off);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = (k < off) ? prev : cur;
    return v;
  endfunction

  task automatic burst(int len, int off, int alt_off, int alt_mod,
                       bit noise, bit prev_lock, int exp_sel);
    for (int i = 0; i < len; i++) begin
      if (i <= EDGE + 13) dat[i] = (i % 2 == 0);
      else begin
        dat[i] = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
    end
    for (int i = 0; i < len; i++) begin
      int o;
      @(negedge clk);
      if (i <= EDGE) begin
        if (prev_lock) chk("R9 lock held until edge", int'(lock), 1);
      end else if (i < EDGE + LOCK_OFS) begin
        chk((i == EDGE + LOCK_OFS - 1) ? "R6 lock low before window" : "R7 lock low",
            int'(lock), 0);
        chk("R7 sdo low before lock", int'(sdo), 0);
      end else begin
        chk("R6 lock high", int'(lock), 1);
        chk("R8 payload bit", int'(sdo), int'(dat[i-LAT]));
      end
      if (i == len - 1 && i >= EDGE + 15)
        chk("R5 phase_sel", int'(phase_sel), exp_sel);
      burst_rst = (i < EDGE);
      o = (alt_off >= 0 && i % alt_mod == 0 && i >= EDGE + 6 && i <= EDGE + 13)
          ? alt_off : off;
      if (noise && i >= EDGE + 1 && i <= EDGE + 4)
        samp = (i % 2 != 0) ? 8'hF0 : 8'h0F;
      else
        samp = mk((i == 0) ? 1'b0 : dat[i-1], dat[i], o);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lock in reset", int'(lock), 0);
    chk("R1 sdo in reset", int'(sdo), 0);
    chk("R1 phase_sel in reset", int'(phase_sel), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 lock after reset", int'(lock), 0);
    chk("R1 sdo after reset", int'(sdo), 0);

    for (int t = 0; t < 8; t++)
      burst(40, int'(TBL[t][5:3]), -1, 1, 1'b0, t > 0, int'(TBL[t][2:0]));

    // R4 majority: five edges at slot 2, three at slot 3
    burst(40, 2, 3, 3, 1'b0, 1'b1, 6);
    // R4 tie: four at slot 3, four at slot 2, lowest wins
    burst(40, 3, 2, 2, 1'b0, 1'b1, 6);
    // R3 noise during initialization is ignored
    burst(40, 5, -1, 1, 1'b1, 1'b1, 1);
    // R9 restart in the middle of measurement, then a full burst
    burst(12, 4, -1, 1, 1'b0, 1'b1, 0);
    burst(40, 7, -1, 1, 1'b0, 1'b0, 3);

    // R2 burst_rst held low: no edge, lock stays
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R2 level low keeps lock", int'(lock), 1);
    end
    burst_rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 rising edge keeps lock", int'(lock), 1);
    end
    finish_run();
  end
endmodule